// File: doc/BRIEF.md
# Microcontroller I/O Register Access Unit

This block holds the peripheral register space of a small 8-bit microcontroller. It accepts three kinds of access from the core. Port-style accesses (IN/OUT) carry a 6-bit I/O address. Data-space loads and stores (LD/ST) carry an 8-bit address. Single-bit set, clear and test operations reach only the low I/O range. The block decodes each request and maps both address spaces onto one register file. It returns read data, a bit-test result and two indications: rejected, or not-mine.

The register file contains three general-purpose read/write registers, a read/write control register and an extended register. The control register sits in the upper I/O range and cannot be reached by bit operations. The extended register can be reached only through data-space accesses. There is also a status register whose flags are set by hardware and cleared by writing a one. Reads and the bit test are combinational in the request cycle. Writes take effect at the next clock edge.

Top module: `mcu_ioreg_unit`

## Requirements
- R1: IN (op 1) and OUT (op 2) are accepted for addresses 0x00 to 0x3F. At 0x40 or above, `reject` is 1, nothing is written and `rd_data` is 0. The control register is at I/O address 0x2C.
- R2: A LD (op 3) or ST (op 4) at data address A (A >= 0x20) reaches the register at I/O address A-0x20. For example, data 0x23 is the same register as I/O 0x03.
- R3: The extended register sits at data address 0xA4. It is reachable only by LD/ST. No IN/OUT or bit operation can read or alter it.
- R4: A LD/ST at data address 0x00 to 0x1F asserts `not_mine`, changes no register and returns `rd_data` 0.
- R5: Bit set (op 5), bit clear (op 6) and bit test (op 7) are accepted only at I/O addresses 0x00 to 0x1F. Above that, `reject` is 1, no register changes and `bit_val` is 0.
- R6: The general-purpose registers sit at I/O addresses 0x03, 0x0A and 0x15. Each supports full read/write. Each also supports bit set, clear and test of bit `req_bit`.
- R7: The status register sits at I/O address 0x11. A one on `hw_flag_set[k]` sets flag k at the next edge. A full write (OUT/ST) clears every flag whose write-data bit is 1 and leaves the other flags as they are.
- R8: A bit set on the status register clears only the named flag. A bit clear on the status register changes nothing.
- R9: When hardware sets a flag in the same cycle as a write that clears it, the flag ends up set.
- R10: Writes to any other address are ignored, and reads from any other address return 0.
- R11: `bit_val` equals the addressed bit of the addressed register in the request cycle. For anything other than an accepted bit test, it is 0.
- R12: `rd_data` is valid in the request cycle of an accepted IN/LD and is 0 otherwise. Writes are visible from the following cycle. All registers are 0 after reset. Op 0, or `req_valid` low, means no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 none, 1 IN, 2 OUT, 3 LD, 4 ST, 5 bit set, 6 bit clear, 7 bit test |
| req_addr | input | 8 | I/O address (IN/OUT/bit ops) or data address (LD/ST) |
| req_wdata | input | 8 | Write data for OUT/ST |
| req_bit | input | 3 | Bit index for bit operations |
| hw_flag_set | input | 8 | Hardware set pulses for status flags |
| rd_data | output | 8 | Read data, combinational |
| bit_val | output | 1 | Bit-test result, combinational |
| not_mine | output | 1 | Data address falls in the working-register window |
| reject | output | 1 | Address out of range for the access kind |

## Verification
`rd_data`, `bit_val`, `reject` and `not_mine` are due in the same cycle as the request. The bench drives each request on the falling edge and samples these outputs 1 ns later, before the rising edge. A write, or a hardware flag set, lands at the rising edge that ends its request cycle. The bench model updates after that edge, so the next request observes the new state through an ordinary read. Each request is compared against a bench model built from the address rules, and this covers directed corner cases and seeded random traffic alike.

// File: rtl/mcu_io_pkg.sv
package mcu_io_pkg;

  localparam int DW      = 8;
  localparam int AW      = 8;
  localparam int BW      = $clog2(DW);
  localparam int NSLOT   = 6;
  localparam int W1C_SLOT = 5;

  // ranges
  localparam logic [AW-1:0] IO_SPAN  = 8'h40;
  localparam logic [AW-1:0] BIT_SPAN = 8'h20;
  localparam logic [AW-1:0] DS_OFS   = 8'h20;

  // unified index of each slot (data address minus DS_OFS)
  // slot0..2 general purpose, slot3 control, slot4 extended, slot5 status
  localparam logic [NSLOT-1:0][AW-1:0] SLOT_IDX =
    {8'h11, 8'h84, 8'h2C, 8'h15, 8'h0A, 8'h03};

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_IN   = 3'd1,
    OP_OUT  = 3'd2,
    OP_LD   = 3'd3,
    OP_ST   = 3'd4,
    OP_BSET = 3'd5,
    OP_BCLR = 3'd6,
    OP_BTST = 3'd7
  } io_op_e;

  typedef struct packed {
    logic          rd;
    logic          wr;
    logic          bset;
    logic          bclr;
    logic          btst;
    logic          reject;
    logic          not_mine;
    logic [AW-1:0] idx;
  } io_dec_t;

endpackage

// File: rtl/mcu_io_rstsync.sv
module mcu_io_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mcu_io_decode.sv
module mcu_io_decode
  import mcu_io_pkg::*;
(
  input  logic          valid,
  input  logic [2:0]    op,
  input  logic [AW-1:0] addr,
  output io_dec_t       dec
);

  io_op_e op_e;
  assign op_e = io_op_e'(op);

  always_comb begin
    dec     = '0;
    dec.idx = addr;
    if (valid) begin
      unique case (op_e)
        OP_IN, OP_OUT: begin
          if (addr < IO_SPAN) begin
            dec.rd = (op_e == OP_IN);
            dec.wr = (op_e == OP_OUT);
          end else begin
            dec.reject = 1'b1;
          end
        end
        OP_LD, OP_ST: begin
          if (addr < DS_OFS) begin
            dec.not_mine = 1'b1;
          end else begin
            dec.idx = addr - DS_OFS;
            dec.rd  = (op_e == OP_LD);
            dec.wr  = (op_e == OP_ST);
          end
        end
        OP_BSET, OP_BCLR, OP_BTST: begin
          if (addr < BIT_SPAN) begin
            dec.bset = (op_e == OP_BSET);
            dec.bclr = (op_e == OP_BCLR);
            dec.btst = (op_e == OP_BTST);
          end else begin
            dec.reject = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mcu_io_rwreg.sv
module mcu_io_rwreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic         en_set,
  input  logic         en_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;
  logic         ld_en;

  always_comb begin
    nxt = q;
    if (en_wr)       nxt = wdata;
    else if (en_set) nxt = q | mask;
    else if (en_clr) nxt = q & ~mask;
  end

  assign ld_en = en_wr | en_set | en_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (ld_en) q <= nxt;
  end

endmodule

// File: rtl/mcu_io_w1c.sv
module mcu_io_w1c #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic         en_set,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);

  logic [W-1:0] clr_vec;
  logic [W-1:0] nxt;
  logic         ld_en;

  // full write clears every written one, bit set clears only the named bit,
  // bit clear writes a zero and so clears nothing
  always_comb begin
    clr_vec = '0;
    if (en_wr)       clr_vec = wdata;
    else if (en_set) clr_vec = mask;
    nxt = (q & ~clr_vec) | hw_set;
  end

  assign ld_en = (|clr_vec) | (|hw_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (ld_en) q <= nxt;
  end

endmodule

// File: rtl/mcu_io_rdmux.sv
module mcu_io_rdmux #(
  parameter int N = 6,
  parameter int W = 8
) (
  input  logic [N-1:0]        hit,
  input  logic [N-1:0][W-1:0] vals,
  output logic [W-1:0]        dout
);

  always_comb begin
    dout = '0;
    for (int s = 0; s < N; s++) begin
      dout = dout | (vals[s] & {W{hit[s]}});
    end
  end

endmodule

// File: rtl/mcu_ioreg_unit.sv
module mcu_ioreg_unit
  import mcu_io_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [7:0]    req_addr,
  input  logic [7:0]    req_wdata,
  input  logic [2:0]    req_bit,
  input  logic [7:0]    hw_flag_set,
  output logic [7:0]    rd_data,
  output logic          bit_val,
  output logic          not_mine,
  output logic          reject
);

  logic                   rst_sync_n;
  io_dec_t                dec;
  logic                   any_acc;
  logic [NSLOT-1:0]       hit;
  logic [NSLOT-1:0][DW-1:0] slot_q;
  logic [DW-1:0]          sel_val;
  logic [DW-1:0]          bmask;
  logic [DW-1:0]          status_q;

  mcu_io_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcu_io_decode u_dec (
    .valid (req_valid),
    .op    (req_op),
    .addr  (req_addr),
    .dec   (dec)
  );

  assign any_acc = dec.rd | dec.wr | dec.bset | dec.bclr | dec.btst;
  assign bmask   = DW'(1) << req_bit;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign hit[s] = any_acc && (dec.idx == SLOT_IDX[s]);
    if (s == W1C_SLOT) begin : g_w1c
      mcu_io_w1c #(.W(DW)) u_reg (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .en_wr  (hit[s] & dec.wr),
        .en_set (hit[s] & dec.bset),
        .wdata  (req_wdata),
        .mask   (bmask),
        .hw_set (hw_flag_set),
        .q      (slot_q[s])
      );
    end else begin : g_rw
      mcu_io_rwreg #(.W(DW)) u_reg (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .en_wr  (hit[s] & dec.wr),
        .en_set (hit[s] & dec.bset),
        .en_clr (hit[s] & dec.bclr),
        .wdata  (req_wdata),
        .mask   (bmask),
        .q      (slot_q[s])
      );
    end
  end

  assign status_q = slot_q[W1C_SLOT];

  mcu_io_rdmux #(.N(NSLOT), .W(DW)) u_mux (
    .hit  (hit),
    .vals (slot_q),
    .dout (sel_val)
  );

  assign rd_data  = dec.rd   ? sel_val : '0;
  assign bit_val  = dec.btst ? sel_val[req_bit] : 1'b0;
  assign not_mine = dec.not_mine;
  assign reject   = dec.reject;

endmodule

// File: rtl/mcu_io_chk.sv
module mcu_io_chk
  import mcu_io_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [7:0]       req_addr,
  input logic [2:0]       req_bit,
  input logic [7:0]       hw_flag_set,
  input logic [7:0]       rd_data,
  input logic             bit_val,
  input logic             not_mine,
  input logic             reject,
  input logic [7:0]       status_q,
  input logic [NSLOT-1:0] hit
);

  logic is_io, is_ds, is_bit, is_read;
  assign is_io   = req_valid && (req_op == 3'd1 || req_op == 3'd2);
  assign is_ds   = req_valid && (req_op == 3'd3 || req_op == 3'd4);
  assign is_bit  = req_valid && (req_op >= 3'd5);
  assign is_read = req_valid && (req_op == 3'd1 || req_op == 3'd3);

  // R1
  io_range_reject_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_io && req_addr >= 8'h40) |-> (reject && rd_data == 8'h00));

  // R4
  ds_low_not_mine_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_ds && req_addr < 8'h20) |-> (not_mine && !reject && rd_data == 8'h00));

  // R5
  bit_range_reject_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_bit && req_addr >= 8'h20) |-> (reject && !bit_val));

  // R10
  reserved_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_read && hit == '0) |-> (rd_data == 8'h00));

  // R9
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|hw_flag_set) |=> ((status_q & $past(hw_flag_set)) == $past(hw_flag_set)));

  // R8
  status_bclr_noop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_op == 3'd6 && req_addr == 8'h11 && hw_flag_set == 8'h00)
    |=> $stable(status_q));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!req_valid && hw_flag_set == 8'h00) |=> $stable(status_q));

  // R11
  bit_val_only_test_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(req_valid && req_op == 3'd7) |-> !bit_val);

endmodule

bind mcu_ioreg_unit mcu_io_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .req_bit     (req_bit),
  .hw_flag_set (hw_flag_set),
  .rd_data     (rd_data),
  .bit_val     (bit_val),
  .not_mine    (not_mine),
  .reject      (reject),
  .status_q    (status_q),
  .hit         (hit)
);

// File: tb/mcu_ioreg_unit_tb.sv
`timescale 1ns/1ps
module mcu_ioreg_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_op;
  logic [7:0] req_addr;
  logic [7:0] req_wdata;
  logic [2:0] req_bit;
  logic [7:0] hw_flag_set;
  logic [7:0] rd_data;
  logic       bit_val;
  logic       not_mine;
  logic       reject;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] m [6];

  always #2.5 clk = ~clk;

  mcu_ioreg_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bit(req_bit),
    .hw_flag_set(hw_flag_set), .rd_data(rd_data), .bit_val(bit_val),
    .not_mine(not_mine), .reject(reject)
  );

  // bench-side address rules
  function automatic int slot_at(input logic [7:0] u);
    case (u)
      8'h03: return 0;
      8'h0A: return 1;
      8'h15: return 2;
      8'h2C: return 3;
      8'h84: return 4;
      8'h11: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic void model_dec(input logic [2:0] op, input logic [7:0] a,
                                    output int slot, output bit rej,
                                    output bit nm, output bit act);
    slot = -1; rej = 0; nm = 0; act = 0;
    if (op == 3'd1 || op == 3'd2) begin
      if (a < 8'h40) begin act = 1; slot = slot_at(a); end else rej = 1;
    end else if (op == 3'd3 || op == 3'd4) begin
      if (a < 8'h20) nm = 1; else begin act = 1; slot = slot_at(a - 8'h20); end
    end else if (op >= 3'd5) begin
      if (a < 8'h20) begin act = 1; slot = slot_at(a); end else rej = 1;
    end
  endfunction

  function automatic string tag_for(input logic [2:0] op, input logic [7:0] a);
    int s; bit r, n, x;
    model_dec(op, a, s, r, n, x);
    if (n) return "R4";
    if (r) return (op >= 3'd5) ? "R5" : "R1";
    if (op == 3'd0) return "R12";
    if (s == -1) return "R10";
    if (s == 4) return "R3";
    if (s == 5) return (op >= 3'd5) ? "R8" : "R7";
    if (op == 3'd7) return "R11";
    if (op == 3'd3 || op == 3'd4) return "R2";
    return "R6";
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] wd, input logic [2:0] bs,
                       input logic [7:0] hw, input string tag);
    int s; bit r, n, x;
    logic [7:0] er; logic eb; logic [7:0] clr;
    @(negedge clk);
    req_valid = (op != 3'd0); req_op = op; req_addr = a;
    req_wdata = wd; req_bit = bs; hw_flag_set = hw;
    #1;
    model_dec(op, a, s, r, n, x);
    er = ((op == 3'd1 || op == 3'd3) && x && s >= 0) ? m[s] : 8'h00;
    eb = (op == 3'd7 && x && s >= 0) ? m[s][bs] : 1'b0;
    n_chk++;
    if (rd_data !== er || bit_val !== eb || reject !== r || not_mine !== n) begin
      n_fail++;
      $display("FAIL %s op=%0d addr=%h: rd=%h/%h bit=%b/%b rej=%b/%b nm=%b/%b (actual/expected)",
               tag, op, a, rd_data, er, bit_val, eb, reject, r, not_mine, n);
    end
    @(posedge clk);
    clr = 8'h00;
    if (x && s == 5) begin
      if (op == 3'd2 || op == 3'd4) clr = wd;
      else if (op == 3'd5) clr = 8'h01 << bs;
    end else if (x && s >= 0) begin
      if (op == 3'd2 || op == 3'd4) m[s] = wd;
      else if (op == 3'd5) m[s] = m[s] | (8'h01 << bs);
      else if (op == 3'd6) m[s] = m[s] & ~(8'h01 << bs);
    end
    m[5] = (m[5] & ~clr) | hw;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [12];
    void'($urandom(32'd20240611));
    pool = '{8'h03, 8'h0A, 8'h15, 8'h11, 8'h2C, 8'h23, 8'h31, 8'hA4,
             8'h4C, 8'h1F, 8'h40, 8'h05};
    for (int i = 0; i < 6; i++) m[i] = 8'h00;
    rst_n = 1'b0; req_valid = 0; req_op = 0; req_addr = 0;
    req_wdata = 0; req_bit = 0; hw_flag_set = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R12: reset values
    do_op(3'd1, 8'h03, 0, 0, 0, "R12");
    do_op(3'd1, 8'h11, 0, 0, 0, "R12");
    do_op(3'd3, 8'hA4, 0, 0, 0, "R12");
    // R6
    do_op(3'd2, 8'h03, 8'hA5, 0, 0, "R6");
    do_op(3'd1, 8'h03, 0, 0, 0, "R6");
    do_op(3'd5, 8'h03, 0, 3'd1, 0, "R6");
    do_op(3'd7, 8'h03, 0, 3'd1, 0, "R11");
    do_op(3'd6, 8'h03, 0, 3'd0, 0, "R6");
    do_op(3'd1, 8'h03, 0, 0, 0, "R6");
    // R2
    do_op(3'd4, 8'h2A, 8'h3C, 0, 0, "R2");
    do_op(3'd1, 8'h0A, 0, 0, 0, "R2");
    do_op(3'd2, 8'h15, 8'h81, 0, 0, "R2");
    do_op(3'd3, 8'h35, 0, 0, 0, "R2");
    // R3
    do_op(3'd4, 8'hA4, 8'h77, 0, 0, "R3");
    do_op(3'd2, 8'h3F, 8'h00, 0, 0, "R3");
    do_op(3'd1, 8'h3F, 0, 0, 0, "R3");
    do_op(3'd3, 8'hA4, 0, 0, 0, "R3");
    // R1
    do_op(3'd1, 8'h4C, 0, 0, 0, "R1");
    do_op(3'd2, 8'h50, 8'hFF, 0, 0, "R1");
    do_op(3'd2, 8'h2C, 8'h5A, 0, 0, "R1");
    do_op(3'd3, 8'h4C, 0, 0, 0, "R1");
    // R4
    do_op(3'd4, 8'h03, 8'hFF, 0, 0, "R4");
    do_op(3'd3, 8'h03, 0, 0, 0, "R4");
    do_op(3'd1, 8'h03, 0, 0, 0, "R4");
    // R5
    do_op(3'd5, 8'h2C, 0, 3'd0, 0, "R5");
    do_op(3'd7, 8'h2C, 0, 3'd1, 0, "R5");
    do_op(3'd1, 8'h2C, 0, 0, 0, "R5");
    // R7
    do_op(3'd0, 8'h00, 0, 0, 8'hF0, "R7");
    do_op(3'd1, 8'h11, 0, 0, 0, "R7");
    do_op(3'd2, 8'h11, 8'h30, 0, 0, "R7");
    do_op(3'd1, 8'h11, 0, 0, 0, "R7");
    // R8
    do_op(3'd5, 8'h11, 0, 3'd7, 0, "R8");
    do_op(3'd1, 8'h11, 0, 0, 0, "R8");
    do_op(3'd6, 8'h11, 0, 3'd6, 0, "R8");
    do_op(3'd1, 8'h11, 0, 0, 0, "R8");
    // R9
    do_op(3'd2, 8'h11, 8'h40, 0, 8'h40, "R9");
    do_op(3'd5, 8'h11, 0, 3'd6, 8'h40, "R9");
    do_op(3'd1, 8'h11, 0, 0, 0, "R9");
    // R10
    do_op(3'd2, 8'h05, 8'hFF, 0, 0, "R10");
    do_op(3'd1, 8'h05, 0, 0, 0, "R10");
    do_op(3'd3, 8'h60, 0, 0, 0, "R10");

    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] op; logic [7:0] a; logic [7:0] hw;
      op = 3'($urandom % 8);
      a  = ($urandom % 2 == 0) ? pool[$urandom % 12] : 8'($urandom);
      hw = ($urandom % 4 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
      do_op(op, a, 8'($urandom), 3'($urandom), hw, tag_for(op, a));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule